// File: doc/BRIEF.md
# Chip Reset Sequencer

The sequencer owns the chip-level hard and soft reset lines. After power-on it keeps both lines asserted. It samples the clock-mode strap pins while it waits for the power-on input to drop and the PLL to lock. It then opens a counted reset window. At the end of a hard window it latches a configuration word from the data pins and releases the lines. After a short settle time it looks at the external pins again, and it re-enters the sequence if outside logic is still pulling either pin.

During normal operation a sequence can be started by the external pins or by internal requests. The internal sources are a watchdog expiry, a core checkstop (only when the checkstop-reset enable is set), a debug port asking for a hard or a soft reset, and a JTAG reset. The hard and soft pins are bidirectional on the package. Here each one is split into a sense input and a drive output, and the board wires the two together. A one-hot cause register records what started the most recent sequence.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_i` is high, and afterwards until `pll_lock_i` is seen high, both drive outputs are 1, `running_o` is 0 and the cause is power-on.
- R2: `clk_mode_o` takes `mode_pins_i` on every clock of the power-on hold, including the clock that leaves it. It then stays frozen until the next power-on.
- R3: A hard sequence drives both outputs high for exactly WINDOW_CYCLES clocks (default 512).
- R4: On the final clock of a hard window, `cfg_word_o` latches `data_pins_i` and `cfg_valid_o` becomes 1. The word changes at no other time.
- R5: After any window both drives are low for SETTLE_CYCLES clocks (default 16), and then the pins are re-tested. A sensed hard pin restarts a hard sequence with cause external-hard. Otherwise a sensed soft pin restarts a soft sequence. If neither pin is sensed, `running_o` rises.
- R6: In normal operation, a sensed hard pin starts a hard sequence and a sensed soft pin starts a soft sequence.
- R7: A watchdog expiry starts a hard sequence.
- R8: A checkstop starts a hard sequence only when `chkstop_rst_en_i` is 1. Otherwise it changes neither the outputs nor the cause.
- R9: A debug hard request starts a hard sequence. A debug soft request or a JTAG reset starts a soft sequence.
- R10: A soft sequence drives only `srst_drive_o`, for WINDOW_CYCLES clocks, and leaves the configuration word untouched.
- R11: `rst_cause_o` is one-hot. Bit 0 is power-on, 1 external hard, 2 external soft, 3 watchdog, 4 checkstop, 5 debug hard, 6 debug soft and 7 JTAG. It is reloaded only when a sequence starts and returns to power-on only through `por_i`.
- R12: A hard request beats a soft request in the same clock. Among hard sources the order is external pin, watchdog, checkstop, debug. Among soft sources it is external pin, debug, JTAG. A hard request during a soft window restarts as hard. A soft request during a hard window is ignored.
- R13: Internal requests are ignored during the power-on hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| pll_lock_i | input | 1 | PLL lock indication |
| mode_pins_i | input | MODE_W | Clock-mode strap pins |
| data_pins_i | input | CFG_W | Data pins carrying the configuration word |
| hrst_sense_i | input | 1 | Hard reset pin level, 1 = asserted |
| srst_sense_i | input | 1 | Soft reset pin level, 1 = asserted |
| wdog_expire_i | input | 1 | Watchdog expiry |
| chkstop_i | input | 1 | Core checkstop |
| chkstop_rst_en_i | input | 1 | Checkstop-reset enable |
| dbg_hard_req_i | input | 1 | Debug port hard reset request |
| dbg_soft_req_i | input | 1 | Debug port soft reset request |
| jtag_rst_i | input | 1 | JTAG reset request |
| hrst_drive_o | output | 1 | Hard reset pin drive enable |
| srst_drive_o | output | 1 | Soft reset pin drive enable |
| clk_mode_o | output | MODE_W | Sampled clock mode |
| cfg_word_o | output | CFG_W | Captured configuration word |
| cfg_valid_o | output | 1 | Configuration word captured since power-on |
| rst_cause_o | output | 8 | One-hot cause of the last reset |
| running_o | output | 1 | Normal operation |

## Verification
The bench provokes three kinds of collision:

- A hard request and a soft request in the same clock, for example a watchdog expiry together with a JTAG reset.
- A debug hard request issued during a soft window.
- A hard request timed onto the last window clock, which is the clock that would otherwise latch the configuration word.

In the last case the restart must win: no capture takes place and a full new window is counted. A behavioural model in the bench gives the expected drives, cause and word on every clock. It models the pins as the wired-OR of the sequencer's drive and an external puller. That lets the re-test at the end of the settle time be judged while the bench holds the pin from outside.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    typedef enum logic [1:0] {
        PH_POR    = 2'd0,
        PH_WIN    = 2'd1,
        PH_SETTLE = 2'd2,
        PH_RUN    = 2'd3
    } phase_e;

    localparam int CAUSE_W   = 8;
    localparam int C_POR     = 0;
    localparam int C_EXT_H   = 1;
    localparam int C_EXT_S   = 2;
    localparam int C_WDOG    = 3;
    localparam int C_CHK     = 4;
    localparam int C_DBG_H   = 5;
    localparam int C_DBG_S   = 6;
    localparam int C_JTAG    = 7;
endpackage

// File: rtl/rsc_req_arb.sv
module rsc_req_arb
    import rsc_pkg::*;
(
    input  phase_e              phase,
    input  logic                seq_hard,
    input  logic                retest,
    input  logic                hsense,
    input  logic                ssense,
    input  logic                wdog,
    input  logic                chk,
    input  logic                chk_en,
    input  logic                dbg_h,
    input  logic                dbg_s,
    input  logic                jtag,
    output logic                start_hard,
    output logic                start_soft,
    output logic [CAUSE_W-1:0]  start_cause
);
    logic ext_h_ok, ext_s_ok, open_h, open_s;
    logic [CAUSE_W-1:0] hard_cause, soft_cause;

    always_comb begin
        open_h   = (phase != PH_POR);
        open_s   = (phase == PH_RUN) || (phase == PH_SETTLE) ||
                   ((phase == PH_WIN) && !seq_hard);
        ext_h_ok = hsense && ((phase == PH_RUN) || retest ||
                   ((phase == PH_WIN) && !seq_hard));
        ext_s_ok = ssense && ((phase == PH_RUN) || retest);

        hard_cause = '0;
        if (ext_h_ok)          hard_cause[C_EXT_H] = 1'b1;
        else if (wdog)         hard_cause[C_WDOG]  = 1'b1;
        else if (chk && chk_en) hard_cause[C_CHK]  = 1'b1;
        else if (dbg_h)        hard_cause[C_DBG_H] = 1'b1;

        soft_cause = '0;
        if (ext_s_ok)          soft_cause[C_EXT_S] = 1'b1;
        else if (dbg_s)        soft_cause[C_DBG_S] = 1'b1;
        else if (jtag)         soft_cause[C_JTAG]  = 1'b1;

        start_hard  = open_h && (hard_cause != '0);
        start_soft  = !start_hard && open_s && (soft_cause != '0);
        start_cause = start_hard ? hard_cause :
                      (start_soft ? soft_cause : '0);
    end
endmodule

// File: rtl/rsc_seq_fsm.sv
module rsc_seq_fsm
    import rsc_pkg::*;
#(
    parameter int WINDOW_CYCLES = 512,
    parameter int SETTLE_CYCLES = 16
) (
    input  logic   clk,
    input  logic   por,
    input  logic   pll_lock,
    input  logic   start_hard,
    input  logic   start_soft,
    output phase_e phase,
    output logic   seq_hard,
    output logic   retest,
    output logic   capture,
    output logic   hrst_drv,
    output logic   srst_drv,
    output logic   running
);
    localparam int MAXC = (WINDOW_CYCLES > SETTLE_CYCLES) ? WINDOW_CYCLES : SETTLE_CYCLES;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] WIN_LOAD = CW'(WINDOW_CYCLES - 1);
    localparam logic [CW-1:0] SET_LOAD = CW'(SETTLE_CYCLES - 1);

    typedef struct packed {
        phase_e        ph;
        logic          hard;
        logic [CW-1:0] cnt;
        logic          hdrv;
        logic          sdrv;
    } fsm_t;

    fsm_t s_d, s_q;
    logic cnt_zero;

    always_comb begin
        cnt_zero = (s_q.cnt == '0);
        retest   = (s_q.ph == PH_SETTLE) && cnt_zero;
        capture  = (s_q.ph == PH_WIN) && s_q.hard && cnt_zero &&
                   !start_hard && !start_soft;

        s_d = s_q;
        if (s_q.ph == PH_POR) begin
            if (pll_lock) begin
                s_d.ph   = PH_WIN;
                s_d.hard = 1'b1;
                s_d.cnt  = WIN_LOAD;
            end
        end else if (start_hard) begin
            s_d.ph   = PH_WIN;
            s_d.hard = 1'b1;
            s_d.cnt  = WIN_LOAD;
        end else if (start_soft) begin
            s_d.ph   = PH_WIN;
            s_d.hard = 1'b0;
            s_d.cnt  = WIN_LOAD;
        end else begin
            unique case (s_q.ph)
                PH_WIN: begin
                    if (cnt_zero) begin
                        s_d.ph  = PH_SETTLE;
                        s_d.cnt = SET_LOAD;
                    end else begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end
                end
                PH_SETTLE: begin
                    if (cnt_zero) s_d.ph  = PH_RUN;
                    else          s_d.cnt = s_q.cnt - 1'b1;
                end
                default: ;
            endcase
        end
        s_d.hdrv = (s_d.ph == PH_POR) || ((s_d.ph == PH_WIN) && s_d.hard);
        s_d.sdrv = (s_d.ph == PH_POR) || (s_d.ph == PH_WIN);
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            s_q.ph   <= PH_POR;
            s_q.hard <= 1'b1;
            s_q.cnt  <= '0;
            s_q.hdrv <= 1'b1;
            s_q.sdrv <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase    = s_q.ph;
    assign seq_hard = s_q.hard;
    assign hrst_drv = s_q.hdrv;
    assign srst_drv = s_q.sdrv;
    assign running  = (s_q.ph == PH_RUN);

    p_hard_needs_soft_r3: assert property (@(posedge clk) disable iff (por)
        hrst_drv |-> srst_drv);
    p_run_released_r5: assert property (@(posedge clk) disable iff (por)
        running |-> (!hrst_drv && !srst_drv));
    p_win_count_bound_r3: assert property (@(posedge clk) disable iff (por)
        (s_q.ph == PH_WIN) |-> (s_q.cnt <= WIN_LOAD));
    p_settle_to_run_r5: assert property (@(posedge clk) disable iff (por)
        (retest && !start_hard && !start_soft) |=> running);
endmodule

// File: rtl/rsc_capture.sv
module rsc_capture
    import rsc_pkg::*;
#(
    parameter int MODE_W = 2,
    parameter int CFG_W  = 32
) (
    input  logic               clk,
    input  logic               por,
    input  logic               in_por_hold,
    input  logic               capture,
    input  logic               start,
    input  logic [CAUSE_W-1:0] start_cause,
    input  logic [MODE_W-1:0]  mode_pins,
    input  logic [CFG_W-1:0]   data_pins,
    output logic [MODE_W-1:0]  clk_mode,
    output logic [CFG_W-1:0]   cfg_word,
    output logic               cfg_valid,
    output logic [CAUSE_W-1:0] cause
);
    typedef struct packed {
        logic [MODE_W-1:0]  mode;
        logic [CFG_W-1:0]   cfg;
        logic               vld;
        logic [CAUSE_W-1:0] cause;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (in_por_hold) c_d.mode = mode_pins;
        if (capture) begin
            c_d.cfg = data_pins;
            c_d.vld = 1'b1;
        end
        if (start) c_d.cause = start_cause;
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            c_q.mode  <= '0;
            c_q.cfg   <= '0;
            c_q.vld   <= 1'b0;
            c_q.cause <= CAUSE_W'(1) << C_POR;
        end else begin
            c_q <= c_d;
        end
    end

    assign clk_mode  = c_q.mode;
    assign cfg_word  = c_q.cfg;
    assign cfg_valid = c_q.vld;
    assign cause     = c_q.cause;

    p_cause_onehot_r11: assert property (@(posedge clk) disable iff (por)
        $countones(cause) == 1);
    p_cfg_hold_r4: assert property (@(posedge clk) disable iff (por)
        !capture |=> $stable(cfg_word));
    p_mode_frozen_r2: assert property (@(posedge clk) disable iff (por)
        !in_por_hold |=> $stable(clk_mode));
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rsc_pkg::*;
#(
    parameter int WINDOW_CYCLES = 512,
    parameter int SETTLE_CYCLES = 16,
    parameter int MODE_W        = 2,
    parameter int CFG_W         = 32
) (
    input  logic              clk,
    input  logic              por_i,
    input  logic              pll_lock_i,
    input  logic [MODE_W-1:0] mode_pins_i,
    input  logic [CFG_W-1:0]  data_pins_i,
    input  logic              hrst_sense_i,
    input  logic              srst_sense_i,
    input  logic              wdog_expire_i,
    input  logic              chkstop_i,
    input  logic              chkstop_rst_en_i,
    input  logic              dbg_hard_req_i,
    input  logic              dbg_soft_req_i,
    input  logic              jtag_rst_i,
    output logic              hrst_drive_o,
    output logic              srst_drive_o,
    output logic [MODE_W-1:0] clk_mode_o,
    output logic [CFG_W-1:0]  cfg_word_o,
    output logic              cfg_valid_o,
    output logic [7:0]        rst_cause_o,
    output logic              running_o
);
    phase_e             phase;
    logic               seq_hard, retest, capture;
    logic               start_hard, start_soft;
    logic [CAUSE_W-1:0] start_cause;

    rsc_req_arb u_arb (
        .phase       (phase),
        .seq_hard    (seq_hard),
        .retest      (retest),
        .hsense      (hrst_sense_i),
        .ssense      (srst_sense_i),
        .wdog        (wdog_expire_i),
        .chk         (chkstop_i),
        .chk_en      (chkstop_rst_en_i),
        .dbg_h       (dbg_hard_req_i),
        .dbg_s       (dbg_soft_req_i),
        .jtag        (jtag_rst_i),
        .start_hard  (start_hard),
        .start_soft  (start_soft),
        .start_cause (start_cause)
    );

    rsc_seq_fsm #(
        .WINDOW_CYCLES (WINDOW_CYCLES),
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_fsm (
        .clk        (clk),
        .por        (por_i),
        .pll_lock   (pll_lock_i),
        .start_hard (start_hard),
        .start_soft (start_soft),
        .phase      (phase),
        .seq_hard   (seq_hard),
        .retest     (retest),
        .capture    (capture),
        .hrst_drv   (hrst_drive_o),
        .srst_drv   (srst_drive_o),
        .running    (running_o)
    );

    rsc_capture #(
        .MODE_W (MODE_W),
        .CFG_W  (CFG_W)
    ) u_cap (
        .clk         (clk),
        .por         (por_i),
        .in_por_hold (phase == PH_POR),
        .capture     (capture),
        .start       (start_hard || start_soft),
        .start_cause (start_cause),
        .mode_pins   (mode_pins_i),
        .data_pins   (data_pins_i),
        .clk_mode    (clk_mode_o),
        .cfg_word    (cfg_word_o),
        .cfg_valid   (cfg_valid_o),
        .cause       (rst_cause_o)
    );

    logic others_idle;
    assign others_idle = !hrst_sense_i && !srst_sense_i && !wdog_expire_i &&
                         !dbg_hard_req_i && !dbg_soft_req_i && !jtag_rst_i;

    p_chk_masked_r8: assert property (@(posedge clk) disable iff (por_i)
        (running_o && chkstop_i && !chkstop_rst_en_i && others_idle)
        |=> (running_o && $stable(rst_cause_o)));
    p_hard_wins_r12: assert property (@(posedge clk) disable iff (por_i)
        (running_o && dbg_hard_req_i && dbg_soft_req_i) |=> hrst_drive_o);
    p_wdog_starts_r7: assert property (@(posedge clk) disable iff (por_i)
        (running_o && wdog_expire_i) |=> (hrst_drive_o && srst_drive_o));
    p_jtag_soft_r9: assert property (@(posedge clk) disable iff (por_i)
        (running_o && jtag_rst_i && !hrst_sense_i && !wdog_expire_i &&
         !(chkstop_i && chkstop_rst_en_i) && !dbg_hard_req_i)
        |=> (srst_drive_o && !hrst_drive_o));
endmodule

// File: tb/rst_seq_ctrl_test.sv
module rst_seq_ctrl_test;
    localparam int W = 512;
    localparam int S = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        por = 1'b1, lock = 1'b0;
    logic [1:0]  mode = 2'b10;
    logic [31:0] data = 32'hA5C3_0F1E;
    logic        ext_h = 1'b0, ext_s = 1'b0;
    logic        wdog = 1'b0, chk = 1'b0, chk_en = 1'b0;
    logic        dbg_h = 1'b0, dbg_s = 1'b0, jtag = 1'b0;
    logic        hsense, ssense;
    logic        hdrv, sdrv, cfgv, run;
    logic [1:0]  cmode;
    logic [31:0] cfg;
    logic [7:0]  cause;

    assign hsense = ext_h | hdrv;
    assign ssense = ext_s | sdrv;

    rst_seq_ctrl #(.WINDOW_CYCLES(W), .SETTLE_CYCLES(S), .MODE_W(2), .CFG_W(32)) uut (
        .clk(clk), .por_i(por), .pll_lock_i(lock), .mode_pins_i(mode),
        .data_pins_i(data), .hrst_sense_i(hsense), .srst_sense_i(ssense),
        .wdog_expire_i(wdog), .chkstop_i(chk), .chkstop_rst_en_i(chk_en),
        .dbg_hard_req_i(dbg_h), .dbg_soft_req_i(dbg_s), .jtag_rst_i(jtag),
        .hrst_drive_o(hdrv), .srst_drive_o(sdrv), .clk_mode_o(cmode),
        .cfg_word_o(cfg), .cfg_valid_o(cfgv), .rst_cause_o(cause),
        .running_o(run)
    );

    int errors = 0;
    int checks = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: phase 0 hold, 1 window, 2 settle, 3 running
    int          m_ph = 0;
    int          m_left = 0;
    bit          m_hard = 1'b1;
    logic [7:0]  m_cause = 8'h01;
    logic [31:0] m_cfg = '0;
    bit          m_cfgv = 1'b0;
    logic [1:0]  m_mode = '0;

    always @(posedge clk or posedge por) begin
        if (por) begin
            m_ph = 0; m_left = 0; m_hard = 1'b1; m_cause = 8'h01;
            m_cfg = '0; m_cfgv = 1'b0; m_mode = '0;
        end else begin
            bit hq, sq, rt;
            int hc, sc;
            hq = 1'b0; sq = 1'b0; hc = 0; sc = 0;
            rt = (m_ph == 2) && (m_left == 1);
            if (m_ph == 0) m_mode = mode;
            if (m_ph != 0) begin
                if (m_ph == 3 || m_ph == 2 || (m_ph == 1 && !m_hard)) begin
                    if (jtag)  begin sq = 1'b1; sc = 7; end
                    if (dbg_s) begin sq = 1'b1; sc = 6; end
                    if (ssense && (m_ph == 3 || rt)) begin sq = 1'b1; sc = 2; end
                end
                if (dbg_h)          begin hq = 1'b1; hc = 5; end
                if (chk && chk_en)  begin hq = 1'b1; hc = 4; end
                if (wdog)           begin hq = 1'b1; hc = 3; end
                if (hsense && (m_ph == 3 || rt || (m_ph == 1 && !m_hard)))
                                    begin hq = 1'b1; hc = 1; end
            end
            if (hq) begin
                m_ph = 1; m_left = W; m_hard = 1'b1; m_cause = 8'(1) << hc;
            end else if (sq) begin
                m_ph = 1; m_left = W; m_hard = 1'b0; m_cause = 8'(1) << sc;
            end else begin
                case (m_ph)
                    0: if (lock) begin m_ph = 1; m_left = W; m_hard = 1'b1; end
                    1: if (m_left == 1) begin
                           if (m_hard) begin m_cfg = data; m_cfgv = 1'b1; end
                           m_ph = 2; m_left = S;
                       end else m_left--;
                    2: if (m_left == 1) m_ph = 3; else m_left--;
                    default: ;
                endcase
            end
        end
    end

    // Per-clock comparison, away from the active edge
    always @(negedge clk) begin
        check("R3 hard drive", 32'(hdrv), 32'(m_ph == 0 || (m_ph == 1 && m_hard)));
        check("R10 soft drive", 32'(sdrv), 32'(m_ph == 0 || m_ph == 1));
        check("R5 running", 32'(run), 32'(m_ph == 3));
        check("R11 cause", 32'(cause), 32'(m_cause));
        check("R4 cfg word", cfg, m_cfg);
        check("R4 cfg valid", 32'(cfgv), 32'(m_cfgv));
        check("R2 clock mode", 32'(cmode), 32'(m_mode));
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_wait(int n);
        tick(n);
    endtask

    task automatic wait_run();
        int n = 0;
        while (!run && n < 3000) begin tick(1); n++; end
        tick(2);
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(3);
        check("R1 drives in por", 32'({hdrv, sdrv, run}), 32'b110);
        check("R1 cause por", 32'(cause), 32'h01);
        por = 1'b0;
        tick(3);
        wdog = 1'b1; tick(1); wdog = 1'b0;   // R13: ignored in hold
        tick(2);
        check("R1 hold without lock", 32'({hdrv, sdrv, run}), 32'b110);
        mode = 2'b01; tick(1);
        lock = 1'b1; tick(1);
        mode = 2'b11;
        tick(10);
        check("R2 mode frozen", 32'(cmode), 32'h1);
        wait_run();
        check("R13 cause still por", 32'(cause), 32'h01);
        check("R4 word captured", cfg, 32'hA5C3_0F1E);

        // R7 watchdog, then external hold at re-test (R5)
        data = 32'h1234_5678;
        wdog = 1'b1; tick(1); wdog = 1'b0;
        while (hdrv) tick(1);
        ext_h = 1'b1; tick(S + 3); ext_h = 1'b0;
        wait_run();
        check("R5 retest cause ext hard", 32'(cause), 32'h02);
        check("R4 word recaptured", cfg, 32'h1234_5678);

        // R8 checkstop masked then enabled
        chk = 1'b1; tick(4); chk = 1'b0;
        check("R8 masked running", 32'(run), 32'h1);
        check("R8 masked cause", 32'(cause), 32'h02);
        chk_en = 1'b1; chk = 1'b1; tick(1); chk = 1'b0; chk_en = 1'b0;
        wait_run();
        check("R8 checkstop cause", 32'(cause), 32'h10);

        // R9 JTAG soft, then R12 debug hard restarts it
        data = 32'hDEAD_BEEF;
        jtag = 1'b1; tick(1); jtag = 1'b0;
        tick(100);
        check("R10 soft only", 32'({hdrv, sdrv}), 32'b01);
        dbg_h = 1'b1; tick(1); dbg_h = 1'b0;
        wait_run();
        check("R12 restart hard", 32'(cause), 32'h20);

        // R12 same-clock hard and soft
        wdog = 1'b1; jtag = 1'b1; tick(1); wdog = 1'b0; jtag = 1'b0;
        tick(50);
        dbg_s = 1'b1; tick(1); dbg_s = 1'b0;   // soft during hard window ignored
        wait_run();
        check("R12 hard wins", 32'(cause), 32'h08);

        // R6 external soft pin; R10 word untouched
        data = 32'h0BAD_F00D;
        ext_s = 1'b1; tick(1); ext_s = 1'b0;
        wait_run();
        check("R6 ext soft cause", 32'(cause), 32'h04);
        check("R10 word kept", cfg, 32'hDEAD_BEEF);

        // R6 external hard pin
        ext_h = 1'b1; tick(1); ext_h = 1'b0;
        wait_run();
        check("R6 ext hard cause", 32'(cause), 32'h02);

        // R9 debug soft
        dbg_s = 1'b1; tick(1); dbg_s = 1'b0;
        wait_run();
        check("R9 debug soft cause", 32'(cause), 32'h40);

        // R12 hard request on the last window clock: no capture
        data = 32'h5555_AAAA;
        wdog = 1'b1; tick(1); wdog = 1'b0;
        tick(W - 1);
        data = 32'h7777_0000;
        dbg_h = 1'b1; tick(1); dbg_h = 1'b0;
        check("R12 still in window", 32'(hdrv), 32'h1);
        wait_run();
        check("R3 restarted cause", 32'(cause), 32'h20);

        // R11 only power-on clears the cause
        por = 1'b1; tick(2);
        check("R11 cleared by por", 32'(cause), 32'h01);
        check("R1 drives after por", 32'({hdrv, sdrv}), 32'b11);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule